// File: doc/BRIEF.md
# Tick-Driven Down-Counting Timer

This block is a 32-bit count-down timer. A simple register bus reaches it and an external tick-enable strobe paces it. Software writes a start value, then writes a control byte. The control byte selects the counter width, how the counter behaves at zero, a tick divider and whether the interrupt line is driven. Each divided tick lowers the count by one.

When the count steps from one to zero, a sticky raw interrupt flag is set. The output line carries that flag gated by the interrupt enable. Software drops the flag by writing any value to the clear address. At zero the timer does one of three things, depending on the mode:

- A periodic timer reloads its start value.
- A free-running timer wraps to all ones. Software can invert the count to obtain an up-count.
- A one-shot timer parks at zero and turns itself off.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the load value, count, control byte and raw flag are all zero and `irq` is low.
- R2: A write to address 0 sets both the load value and the count. A write to address 1 sets only the count and leaves the load value unchanged.
- R3: The count drops by one on each divided tick while control bit 7 (enable) is set. With bit 7 clear, which writing 0 to the control byte gives, the count holds and ticks have no effect.
- R4: Control bits 3:2 pick the tick divider: 00 steps on every tick, 01 on every 16th, 10 on every 256th, and 11 acts as 00. Clearing enable restarts the divider.
- R5: With bit 6 (periodic) set and bit 0 clear, a step taken at zero reloads the count from the load value.
- R6: With bits 6 and 0 both clear (free-running), a step taken at zero wraps the count to all ones of the active width.
- R7: With bit 0 (one-shot) set, the step that reaches zero clears the enable bit and the count stays at zero. Bit 0 takes priority over bit 6.
- R8: The raw flag is set on a step from one to zero. `irq` equals the raw flag ANDed with bit 5 (interrupt enable). Address 4 reads the raw flag in bit 0 and address 5 reads `irq` in bit 0.
- R9: Writing any value to address 3 clears the raw flag. If a step sets the flag in the same cycle, the flag stays set.
- R10: With bit 1 (32-bit size) clear, only the low 16 bits count. The count reads with its upper half zero and wraps to 0xFFFF. The load value still reads back in full.
- R11: Address 2 reads the control byte in bits 7:0, with bit 4 always zero. Address 3 and the unused addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | External tick strobe, one cycle per tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The counter is run to zero in each of the three end-of-count modes from the same small start values. The value read one step after zero tells the modes apart: the load value for periodic, all ones for free-running, and a parked zero with the enable bit dropped for one-shot. The divider is tested at the tick just before and the tick just after its boundary for each code, which exposes an off-by-one in the divider. The 16-bit runs separate masking from wrapping. A tick that coincides with a clear write shows which of the two takes priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10
    } presc_e;

    typedef struct packed {
        logic       enable;
        logic       periodic;
        logic       irq_en;
        logic       rsvd;
        logic [1:0] prescale;
        logic       size32;
        logic       oneshot;
    } ctrl_t;

    typedef enum logic [2:0] {
        RA_LOAD   = 3'd0,
        RA_VALUE  = 3'd1,
        RA_CTRL   = 3'd2,
        RA_CLEAR  = 3'd3,
        RA_RAW    = 3'd4,
        RA_MASKED = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int MID_LOG2  = 4,
    parameter int HIGH_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       step
);
    localparam int PS_W = HIGH_LOG2;
    localparam logic [PS_W-1:0] MID_MASK  = PS_W'((1 << MID_LOG2) - 1);
    localparam logic [PS_W-1:0] HIGH_MASK = {PS_W{1'b1}};

    logic [PS_W-1:0] ps_d, ps_q;
    logic            hit;

    always_comb begin
        case (sel)
            PS_DIV16:  hit = (ps_q & MID_MASK) == MID_MASK;
            PS_DIV256: hit = ps_q == HIGH_MASK;
            default:   hit = 1'b1;
        endcase
        step = run & tick & hit;
        if (!run)
            ps_d = '0;
        else if (tick)
            ps_d = ps_q + 1'b1;
        else
            ps_d = ps_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ps_q <= '0;
        else
            ps_q <= ps_d;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              size32,
    input  logic              oneshot,
    input  logic              periodic,
    input  logic              wr_load,
    input  logic              wr_value,
    input  logic              clr_raw,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count_val,
    output logic              raw,
    output logic              stop_req
);
    localparam logic [DATA_W-1:0] WIDE_MASK   = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});
    localparam logic [DATA_W-1:0] ONE         = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] count;
        logic              raw;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [DATA_W-1:0] mask, cur;
    logic              raw_set;

    always_comb begin
        mask    = size32 ? WIDE_MASK : NARROW_MASK;
        cur     = st_q.count & mask;
        st_d    = st_q;
        raw_set = 1'b0;
        if (wr_load) begin
            st_d.load  = wdata;
            st_d.count = wdata;
        end else if (wr_value) begin
            st_d.count = wdata;
        end else if (step) begin
            if (cur == '0) begin
                if (oneshot)
                    st_d.count = '0;
                else if (periodic)
                    st_d.count = st_q.load & mask;
                else
                    st_d.count = mask;
            end else begin
                st_d.count = cur - ONE;
                raw_set    = (cur == ONE);
            end
        end
        if (raw_set)
            st_d.raw = 1'b1;
        else if (clr_raw)
            st_d.raw = 1'b0;
        stop_req  = step & oneshot & (cur <= ONE);
        load_val  = st_q.load;
        count_val = cur;
        raw       = st_q.raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NARROW_W  = 16,
    parameter int ADDR_W    = 3,
    parameter int MID_LOG2  = 4,
    parameter int HIGH_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_d, ctrl_q;
    logic              wr_any, wr_load, wr_value, wr_ctrl, wr_clr;
    logic              step_w, raw_w, stop_w;
    logic [DATA_W-1:0] load_w, count_w;

    assign wr_any   = bus_sel & bus_wr;
    assign wr_load  = wr_any & (bus_addr == ADDR_W'(RA_LOAD));
    assign wr_value = wr_any & (bus_addr == ADDR_W'(RA_VALUE));
    assign wr_ctrl  = wr_any & (bus_addr == ADDR_W'(RA_CTRL));
    assign wr_clr   = wr_any & (bus_addr == ADDR_W'(RA_CLEAR));

    tmr_prescaler #(
        .MID_LOG2 (MID_LOG2),
        .HIGH_LOG2(HIGH_LOG2)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (ctrl_q.enable),
        .tick (tick_en),
        .sel  (ctrl_q.prescale),
        .step (step_w)
    );

    tmr_counter #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_w),
        .size32   (ctrl_q.size32),
        .oneshot  (ctrl_q.oneshot),
        .periodic (ctrl_q.periodic),
        .wr_load  (wr_load),
        .wr_value (wr_value),
        .clr_raw  (wr_clr),
        .wdata    (bus_wdata),
        .load_val (load_w),
        .count_val(count_w),
        .raw      (raw_w),
        .stop_req (stop_w)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d      = ctrl_t'(bus_wdata[CTRL_W-1:0]);
            ctrl_d.rsvd = 1'b0;
        end else if (stop_w) begin
            ctrl_d.enable = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_d;
    end

    assign irq = raw_w & ctrl_q.irq_en;

    always_comb begin
        case (bus_addr)
            ADDR_W'(RA_LOAD):   bus_rdata = load_w;
            ADDR_W'(RA_VALUE):  bus_rdata = count_w;
            ADDR_W'(RA_CTRL):   bus_rdata = DATA_W'(ctrl_q);
            ADDR_W'(RA_RAW):    bus_rdata = DATA_W'(raw_w);
            ADDR_W'(RA_MASKED): bus_rdata = DATA_W'(irq);
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic              wr_any,
    input logic              wr_clr,
    input logic              enable,
    input logic              oneshot,
    input logic              raw,
    input logic [DATA_W-1:0] count
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_any) |=> $stable(count)); // R3

    AST_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_any && count > DATA_W'(1)) |=> count == $past(count) - DATA_W'(1)); // R3

    AST_NO_STEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !step); // R3

    AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_any && oneshot && count == DATA_W'(1)) |=> !enable); // R7

    AST_RAW_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(step)); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !step) |=> !raw); // R9
endmodule

bind tick_down_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step_w),
    .wr_any (wr_any),
    .wr_clr (wr_clr),
    .enable (ctrl_q.enable),
    .oneshot(ctrl_q.oneshot),
    .raw    (raw_w),
    .count  (count_w)
);

// File: tb/sim_tick_down_timer.sv
module sim_tick_down_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    tick_down_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rd_check("R1 load", 3'd0, 32'd0);
        rd_check("R1 count", 3'd1, 32'd0);
        rd_check("R1 ctrl", 3'd2, 32'd0);
        rd_check("R1 raw", 3'd4, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_load_value();
        wr(3'd0, 32'd10);
        rd_check("R2 load", 3'd0, 32'd10);
        rd_check("R2 count after load", 3'd1, 32'd10);
        wr(3'd1, 32'd5);
        rd_check("R2 count write", 3'd1, 32'd5);
        rd_check("R2 load kept", 3'd0, 32'd10);
    endtask

    task automatic t_count_stop();
        wr(3'd2, 32'hC2);
        ticks(3);
        rd_check("R3 decrement", 3'd1, 32'd2);
        wr(3'd2, 32'h0);
        ticks(2);
        rd_check("R3 stopped", 3'd1, 32'd2);
    endtask

    task automatic t_periodic();
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        wr(3'd0, 32'd2);
        wr(3'd2, 32'hE2);
        ticks(2);
        rd_check("R5 at zero", 3'd1, 32'd0);
        rd_check("R8 raw set", 3'd4, 32'd1);
        check("R8 irq high", {31'd0, irq}, 32'd1);
        rd_check("R8 masked", 3'd5, 32'd1);
        ticks(1);
        rd_check("R5 reload", 3'd1, 32'd2);
        wr(3'd3, 32'h1234);
        rd_check("R9 raw cleared", 3'd4, 32'd0);
        check("R9 irq low", {31'd0, irq}, 32'd0);
        wr(3'd2, 32'hC2);
        ticks(2);
        rd_check("R8 raw without ie", 3'd4, 32'd1);
        check("R8 irq gated", {31'd0, irq}, 32'd0);
        rd_check("R8 masked gated", 3'd5, 32'd0);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_free();
        wr(3'd2, 32'h0);
        wr(3'd0, 32'd1);
        wr(3'd2, 32'h82);
        ticks(1);
        rd_check("R6 zero", 3'd1, 32'd0);
        ticks(1);
        rd_check("R6 wrap", 3'd1, 32'hFFFF_FFFF);
        ticks(1);
        rd_check("R6 continue", 3'd1, 32'hFFFF_FFFE);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    endtask

    task automatic t_oneshot();
        wr(3'd0, 32'd2);
        wr(3'd2, 32'hC3);
        ticks(2);
        rd_check("R7 zero", 3'd1, 32'd0);
        rd_check("R7 enable cleared", 3'd2, 32'h43);
        rd_check("R7 raw", 3'd4, 32'd1);
        ticks(2);
        rd_check("R7 parked", 3'd1, 32'd0);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_prescale();
        wr(3'd2, 32'h0);
        wr(3'd0, 32'd100);
        wr(3'd2, 32'h86);
        ticks(15);
        rd_check("R4 div16 before", 3'd1, 32'd100);
        ticks(1);
        rd_check("R4 div16 step", 3'd1, 32'd99);
        wr(3'd2, 32'h0);
        wr(3'd2, 32'h8A);
        ticks(255);
        rd_check("R4 div256 before", 3'd1, 32'd99);
        ticks(1);
        rd_check("R4 div256 step", 3'd1, 32'd98);
        wr(3'd2, 32'h0);
        wr(3'd2, 32'h8E);
        ticks(1);
        rd_check("R4 code11 as div1", 3'd1, 32'd97);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_narrow();
        wr(3'd0, 32'h1234_0002);
        rd_check("R10 masked read", 3'd1, 32'h0000_0002);
        rd_check("R10 load full", 3'd0, 32'h1234_0002);
        wr(3'd2, 32'h80);
        ticks(2);
        rd_check("R10 zero", 3'd1, 32'd0);
        ticks(1);
        rd_check("R10 wrap 16", 3'd1, 32'h0000_FFFF);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    endtask

    task automatic t_collision();
        wr(3'd0, 32'd1);
        wr(3'd2, 32'h82);
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'd0;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd_check("R9 set wins", 3'd4, 32'd1);
        rd_check("R9 count", 3'd1, 32'd0);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    endtask

    task automatic t_map();
        wr(3'd2, 32'hFF);
        rd_check("R11 ctrl bit4 zero", 3'd2, 32'hEF);
        wr(3'd2, 32'h0);
        rd_check("R11 clear reads 0", 3'd3, 32'd0);
        rd_check("R11 addr6", 3'd6, 32'd0);
        rd_check("R11 addr7", 3'd7, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_value();
        t_count_stop();
        t_periodic();
        t_free();
        t_oneshot();
        t_prescale();
        t_narrow();
        t_collision();
        t_map();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end
endmodule